// File: doc/BRIEF.md
# Clock, Reset and Power-Mode Controller

This block generates the internal timing and reset for a small 8-bit microcontroller core. It runs on the raw oscillator clock. A divide-by-two stage feeds a state counter, and the two together form a 12-step phase count that marks each machine cycle. An external active-high reset pin is synchronised and qualified: the core reset fires only after the pin has been high for two full machine cycles. The port latches are forced high combinationally the moment the pin rises. A small power-control register lets software park the CPU in idle or stop everything in power-down.

The CPU and the peripherals each get their own clock-enable strobe, one per internal state (every second oscillator clock). Idle removes only the CPU strobe and ends on an interrupt request at the next machine-cycle boundary. Power-down freezes the phase counter and both strobes, and only a qualified hardware reset ends it. Only the reset qualifier keeps counting oscillator edges in power-down.

Top module: `mcu_clk_pwr_ctrl`

## Requirements
- R1: `phase` counts oscillator periods 0 to 11 within a machine cycle and wraps to 0. `mcyc_end` is high exactly when `phase` is 11 and the counter is running.
- R2: The phase advances on every oscillator edge except in power-down. `periph_ce` pulses exactly on odd phases (every second oscillator clock), so only rising edges matter and the input duty cycle has no effect.
- R3: The pin passes a 2-stage synchroniser. `core_rst` rises on the second edge after the 24th consecutive edge at which the pin is high. A pulse covering 23 edges, or a run broken by one low sample, leaves `core_rst` low.
- R4: `core_rst` falls only at an edge where `mcyc_end` is high and the synchronised pin is low.
- R5: `port_high` is high whenever `rst_pin` or `core_rst` is high, with no clock delay. `port_rst_val` reads FFh and `sp_rst_val` reads 07h.
- R6: In idle (`pcon_rdata` bit 0 = 1), `cpu_ce` stays low while `periph_ce` keeps pulsing on odd phases.
- R7: In idle, an `irq` pulse returns the block to run at the next machine-cycle boundary. Bit 0 clears by hardware and `cpu_ce` resumes.
- R8: In power-down (`pcon_rdata` bit 1 = 1), `phase` holds its value, both strobes stay low and `irq` is ignored. Only a qualified reset returns to run.
- R9: `pcon_rdata` holds bit 0 = idle, bit 1 = power-down, and writable flags in bits 2, 3 and 7. Bits 4 to 6 read 0 and ignore writes.
- R10: A write that sets bits 0 and 1 together enters power-down, and `pcon_rdata[1:0]` reads 10b.
- R11: Writes to `pcon` are ignored while `core_rst` is high or the block is not in run. `core_rst` returns the register to 00h.
- R12: Asserting `por_n` low at once sets `core_rst` high, `phase` to 0 and `pcon_rdata` to 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Raw oscillator clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| rst_pin | input | 1 | External active-high reset pin, asynchronous |
| pcon_we | input | 1 | Power-control register write strobe |
| pcon_wdata | input | 8 | Power-control write data |
| irq | input | 1 | Any enabled interrupt request pending |
| pcon_rdata | output | 8 | Power-control register read value |
| phase | output | 4 | Oscillator period index within the machine cycle |
| mcyc_end | output | 1 | Last period of a machine cycle |
| cpu_ce | output | 1 | CPU clock-enable strobe |
| periph_ce | output | 1 | Timer, serial and interrupt clock-enable strobe |
| core_rst | output | 1 | Synchronous core reset |
| port_high | output | 1 | Forces port latches to 1 |
| port_rst_val | output | 8 | Port latch value loaded on core reset |
| sp_rst_val | output | 8 | Stack pointer value loaded on core reset |

## Verification
The hardest state to reach is leaving power-down. There the phase counter is frozen and no boundary strobe exists, so the reset qualifier must count raw oscillator edges on its own, and the release must wait for the prescaler to restart. The stimulus writes both mode bits at once, sends interrupt pulses that must be ignored, and holds the pin for more than the qualification window. It then follows the release to the first boundary. Pulses one edge short of the window, and runs broken by a single low sample, probe the exact count.

// File: rtl/cpm_pkg.sv
`timescale 1ns/1ps
package cpm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } pmode_e;

  localparam int          PC_IDLE_BIT  = 0;
  localparam int          PC_PDOWN_BIT = 1;
  localparam logic [7:0]  PC_FLAG_MASK = 8'h8C;
endpackage

// File: rtl/cpm_prescaler.sv
`timescale 1ns/1ps
module cpm_prescaler #(
  parameter int DIV    = 2,
  parameter int STATES = 6,
  localparam int CYC_LEN = DIV * STATES,
  localparam int PW      = $clog2(CYC_LEN),
  localparam int DW      = (DIV > 1) ? $clog2(DIV) : 1,
  localparam int SW      = (STATES > 1) ? $clog2(STATES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  output logic          tick_o,
  output logic          mcyc_end_o,
  output logic [PW-1:0] phase_o
);
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);
  localparam logic [SW-1:0] ST_LAST  = SW'(STATES - 1);
  localparam logic [PW-1:0] DIV_P    = PW'(DIV);

  logic [DW-1:0] div_q, div_d;
  logic [SW-1:0] st_q, st_d;

  always_comb begin
    div_d = div_q;
    st_d  = st_q;
    if (run_i) begin
      if (div_q == DIV_LAST) begin
        div_d = '0;
        st_d  = (st_q == ST_LAST) ? '0 : st_q + 1'b1;
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      st_q  <= '0;
    end else begin
      div_q <= div_d;
      st_q  <= st_d;
    end
  end

  assign tick_o     = run_i && (div_q == DIV_LAST);
  assign mcyc_end_o = tick_o && (st_q == ST_LAST);
  assign phase_o    = PW'(st_q) * DIV_P + PW'(div_q);
endmodule

// File: rtl/cpm_rst_qual.sv
`timescale 1ns/1ps
module cpm_rst_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_LEN    = 24,
  localparam int CW = $clog2(QUAL_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic mcyc_end_i,
  output logic core_rst_o
);
  localparam logic [CW-1:0] CNT_MAX  = CW'(QUAL_LEN);
  localparam logic [CW-1:0] CNT_LAST = CW'(QUAL_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   rst_q, rst_d;
  logic                   pin_s;

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    if (!pin_s)                cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    else                       cnt_d = cnt_q;

    rst_d = rst_q;
    if (pin_s && (cnt_q == CNT_LAST))         rst_d = 1'b1;
    else if (rst_q && !pin_s && mcyc_end_i)   rst_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      cnt_q  <= '0;
      rst_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      cnt_q  <= cnt_d;
      rst_q  <= rst_d;
    end
  end

  assign core_rst_o = rst_q;
endmodule

// File: rtl/cpm_pwr_ctrl.sv
`timescale 1ns/1ps
module cpm_pwr_ctrl
  import cpm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       core_rst_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       irq_i,
  input  logic       mcyc_end_i,
  output pmode_e     mode_o,
  output logic [7:0] pcon_o
);
  pmode_e     mode_q, mode_d;
  logic       wake_q, wake_d;
  logic [7:0] flag_q, flag_d;

  always_comb begin
    mode_d = mode_q;
    wake_d = wake_q;
    flag_d = flag_q;
    if (core_rst_i) begin
      mode_d = MODE_RUN;
      wake_d = 1'b0;
      flag_d = '0;
    end else begin
      case (mode_q)
        MODE_RUN: begin
          if (wr_en_i) begin
            flag_d = wr_data_i & PC_FLAG_MASK;
            if (wr_data_i[PC_PDOWN_BIT])     mode_d = MODE_PDOWN;
            else if (wr_data_i[PC_IDLE_BIT]) mode_d = MODE_IDLE;
          end
        end
        MODE_IDLE: begin
          if (irq_i) wake_d = 1'b1;
          if (mcyc_end_i && (wake_q || irq_i)) begin
            mode_d = MODE_RUN;
            wake_d = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RUN;
      wake_q <= 1'b0;
      flag_q <= '0;
    end else begin
      mode_q <= mode_d;
      wake_q <= wake_d;
      flag_q <= flag_d;
    end
  end

  assign mode_o = mode_q;
  always_comb begin
    pcon_o = flag_q;
    pcon_o[PC_IDLE_BIT]  = (mode_q == MODE_IDLE);
    pcon_o[PC_PDOWN_BIT] = (mode_q == MODE_PDOWN);
  end
endmodule

// File: rtl/mcu_clk_pwr_ctrl.sv
`timescale 1ns/1ps
module mcu_clk_pwr_ctrl
  import cpm_pkg::*;
#(
  parameter int         DIV         = 2,
  parameter int         STATES      = 6,
  parameter int         QUAL_CYCLES = 2,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] PORT_RST    = 8'hFF,
  parameter logic [7:0] SP_RST      = 8'h07,
  localparam int CYC_LEN  = DIV * STATES,
  localparam int QUAL_LEN = CYC_LEN * QUAL_CYCLES,
  localparam int PW       = $clog2(CYC_LEN)
) (
  input  logic          clk_osc,
  input  logic          por_n,
  input  logic          rst_pin,
  input  logic          pcon_we,
  input  logic [7:0]    pcon_wdata,
  input  logic          irq,
  output logic [7:0]    pcon_rdata,
  output logic [PW-1:0] phase,
  output logic          mcyc_end,
  output logic          cpu_ce,
  output logic          periph_ce,
  output logic          core_rst,
  output logic          port_high,
  output logic [7:0]    port_rst_val,
  output logic [7:0]    sp_rst_val
);
  pmode_e mode;
  logic   run, tick;

  assign run = (mode != MODE_PDOWN);

  cpm_prescaler #(.DIV(DIV), .STATES(STATES)) u_presc (
    .clk_i      (clk_osc),
    .rst_ni     (por_n),
    .run_i      (run),
    .tick_o     (tick),
    .mcyc_end_o (mcyc_end),
    .phase_o    (phase)
  );

  cpm_rst_qual #(.SYNC_STAGES(SYNC_STAGES), .QUAL_LEN(QUAL_LEN)) u_qual (
    .clk_i      (clk_osc),
    .rst_ni     (por_n),
    .pin_i      (rst_pin),
    .mcyc_end_i (mcyc_end),
    .core_rst_o (core_rst)
  );

  cpm_pwr_ctrl u_pwr (
    .clk_i      (clk_osc),
    .rst_ni     (por_n),
    .core_rst_i (core_rst),
    .wr_en_i    (pcon_we),
    .wr_data_i  (pcon_wdata),
    .irq_i      (irq),
    .mcyc_end_i (mcyc_end),
    .mode_o     (mode),
    .pcon_o     (pcon_rdata)
  );

  assign cpu_ce       = tick && (mode == MODE_RUN);
  assign periph_ce    = tick;
  assign port_high    = rst_pin || core_rst;
  assign port_rst_val = PORT_RST;
  assign sp_rst_val   = SP_RST;
endmodule

// File: rtl/cpm_checker.sv
`timescale 1ns/1ps
module cpm_checker #(
  parameter int PW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rst_pin_i,
  input logic          pcon_we_i,
  input logic [7:0]    pcon_wdata_i,
  input logic [7:0]    pcon_rdata_i,
  input logic [PW-1:0] phase_i,
  input logic          mcyc_end_i,
  input logic          cpu_ce_i,
  input logic          periph_ce_i,
  input logic          core_rst_i,
  input logic          port_high_i
);
  assert_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mcyc_end_i |=> (phase_i == '0));

  assert_ce_odd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periph_ce_i |-> phase_i[0]);

  assert_release_boundary_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_i) |-> $past(mcyc_end_i));

  assert_ports_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pin_i |-> port_high_i);

  assert_idle_cpu_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcon_rdata_i[0] |-> !cpu_ce_i);

  assert_pd_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcon_rdata_i[1] |=> $stable(phase_i));

  assert_pd_no_ce_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcon_rdata_i[1] |-> !(periph_ce_i || cpu_ce_i));

  assert_pd_priority_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcon_we_i && (pcon_wdata_i[1:0] == 2'b11) && (pcon_rdata_i[1:0] == 2'b00) && !core_rst_i)
      |=> (pcon_rdata_i[1:0] == 2'b10));
endmodule

bind mcu_clk_pwr_ctrl cpm_checker #(.PW(PW)) u_chk (
  .clk_i        (clk_osc),
  .rst_ni       (por_n),
  .rst_pin_i    (rst_pin),
  .pcon_we_i    (pcon_we),
  .pcon_wdata_i (pcon_wdata),
  .pcon_rdata_i (pcon_rdata),
  .phase_i      (phase),
  .mcyc_end_i   (mcyc_end),
  .cpu_ce_i     (cpu_ce),
  .periph_ce_i  (periph_ce),
  .core_rst_i   (core_rst),
  .port_high_i  (port_high)
);

// File: tb/sim_mcu_clk_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_mcu_clk_pwr_ctrl;
  logic       clk, por_n, rst_pin, pcon_we, irq;
  logic [7:0] pcon_wdata;
  logic [7:0] pcon_rdata, port_rst_val, sp_rst_val;
  logic [3:0] phase;
  logic       mcyc_end, cpu_ce, periph_ce, core_rst, port_high;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit chk_en = 0;
  bit done   = 0;

  // reference model state
  int m_phase, m_cnt, m_mode, m_flags;
  bit m_rst, m_wake, m_s1, m_s2;

  mcu_clk_pwr_ctrl u0 (
    .clk_osc(clk), .por_n(por_n), .rst_pin(rst_pin), .pcon_we(pcon_we),
    .pcon_wdata(pcon_wdata), .irq(irq), .pcon_rdata(pcon_rdata), .phase(phase),
    .mcyc_end(mcyc_end), .cpu_ce(cpu_ce), .periph_ce(periph_ce), .core_rst(core_rst),
    .port_high(port_high), .port_rst_val(port_rst_val), .sp_rst_val(sp_rst_val)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_phase = 0; m_cnt = 0; m_mode = 0; m_flags = 0;
    m_rst = 1; m_wake = 0; m_s1 = 0; m_s2 = 0;
  endtask

  always @(posedge clk or negedge por_n) begin : model
    bit run, tick, mend, pin_q;
    if (!por_n) begin
      model_reset();
    end else begin
      run   = (m_mode != 2);
      tick  = run && (m_phase % 2 == 1);
      mend  = tick && (m_phase == 11);
      pin_q = m_s2;
      if (m_rst) begin
        m_mode = 0; m_wake = 0; m_flags = 0;
      end else if (m_mode == 0) begin
        if (pcon_we) begin
          m_flags = pcon_wdata & 8'h8C;
          if (pcon_wdata[1])      m_mode = 2;
          else if (pcon_wdata[0]) m_mode = 1;
        end
      end else if (m_mode == 1) begin
        if (mend && (m_wake || irq)) begin m_mode = 0; m_wake = 0; end
        else if (irq) m_wake = 1;
      end
      if (pin_q && m_cnt == 23)            m_rst = 1;
      else if (m_rst && !pin_q && mend)    m_rst = 0;
      m_cnt = !pin_q ? 0 : ((m_cnt < 24) ? m_cnt + 1 : 24);
      m_s2 = m_s1;
      m_s1 = rst_pin;
      if (run) m_phase = (m_phase + 1) % 12;
    end
  end

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin : cmp
    bit run, tick;
    if (chk_en) begin
      run  = (m_mode != 2);
      tick = run && (m_phase % 2 == 1);
      chk("R1 phase", phase, m_phase);
      chk("R1 mcyc_end", mcyc_end, int'(tick && m_phase == 11));
      chk("R2 periph_ce", periph_ce, int'(tick));
      chk("R6 cpu_ce", cpu_ce, int'(tick && m_mode == 0));
      chk("R3 core_rst", core_rst, int'(m_rst));
      chk("R5 port_high", port_high, int'(rst_pin || m_rst));
      chk("R9 pcon_rdata", pcon_rdata,
          m_flags | (m_mode == 1 ? 1 : 0) | (m_mode == 2 ? 2 : 0));
      chk("R5 port_rst_val", port_rst_val, 8'hFF);
      chk("R5 sp_rst_val", sp_rst_val, 8'h07);
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [7:0] d);
    pcon_wdata = d; pcon_we = 1'b1;
    step(1);
    pcon_we = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int pc, cc, ph0;
    por_n = 1'b1; rst_pin = 0; pcon_we = 0; pcon_wdata = 0; irq = 0;
    #1 por_n = 1'b0;
    step(3);
    chk_en = 1;
    // R12 reset state
    chk("R12 core_rst at por", core_rst, 1);
    chk("R12 phase at por", phase, 0);
    chk("R12 pcon at por", pcon_rdata, 0);
    por_n = 1'b1;
    step(14);
    chk("R4 release after por", core_rst, 0);

    // R9 flags and unimplemented bits
    wr(8'h7C); step(1);
    chk("R9 bits 4-6 dropped", pcon_rdata, 8'h0C);
    wr(8'h80); step(1);
    chk("R9 flag bit 7", pcon_rdata, 8'h80);
    wr(8'h00); step(3);

    // R5 immediate port drive, R3 short pulse ignored
    rst_pin = 1; #0.5;
    chk("R5 port_high immediate", port_high, 1);
    step(23);
    rst_pin = 0;
    step(6);
    chk("R3 23-edge pulse ignored", core_rst, 0);

    // R3 broken run ignored
    rst_pin = 1; step(20); rst_pin = 0; step(1); rst_pin = 1; step(20); rst_pin = 0;
    step(5);
    chk("R3 broken run ignored", core_rst, 0);

    // R3 exact 24-edge qualification, R11 write during reset, R4 release
    rst_pin = 1; step(24); rst_pin = 0;
    step(1);
    chk("R3 not yet at edge 25", core_rst, 0);
    step(1);
    chk("R3 asserted at edge 26", core_rst, 1);
    wr(8'h0C); step(1);
    chk("R11 write ignored in reset", pcon_rdata & 8'h0C, 0);
    step(14);
    chk("R4 released at boundary", core_rst, 0);

    // R6 idle keeps peripherals, R11 write ignored in idle, R7 wake
    wr(8'h01);
    pc = 0; cc = 0;
    repeat (40) begin step(1); pc += periph_ce; cc += cpu_ce; end
    chk("R6 periph_ce pulses in idle", pc, 20);
    chk("R6 cpu_ce silent in idle", cc, 0);
    wr(8'h8C); step(1);
    chk("R11 write ignored in idle", pcon_rdata, 8'h01);
    irq = 1; step(1); irq = 0;
    step(12);
    chk("R7 idle bit cleared", pcon_rdata, 8'h00);
    cc = 0;
    repeat (4) begin step(1); cc += cpu_ce; end
    chk("R7 cpu_ce resumed", cc, 2);

    // R10 priority, R8 power-down freeze and exit by reset only
    wr(8'h03); step(1);
    chk("R10 power-down wins", pcon_rdata, 8'h02);
    ph0 = phase; pc = 0;
    irq = 1; step(2); irq = 0;
    repeat (50) begin step(1); pc += periph_ce + cpu_ce; end
    chk("R8 no strobes in power-down", pc, 0);
    chk("R8 phase frozen", phase, ph0);
    chk("R8 irq ignored", pcon_rdata, 8'h02);
    rst_pin = 1; step(30); rst_pin = 0;
    chk("R8 reset qualified in power-down", core_rst, 1);
    step(16);
    chk("R8 left power-down", pcon_rdata, 8'h00);
    chk("R8 reset released", core_rst, 0);

    // R12 asynchronous power-on reset mid-run
    step(5);
    por_n = 0; #0.5;
    chk("R12 async core_rst", core_rst, 1);
    chk("R12 async phase", phase, 0);
    step(2);
    por_n = 1;
    step(20);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule